// File: doc/BRIEF.md
# ADC Conversion Control and Status Register

This block is the control and status slice of an analog-to-digital converter's digital sequencer. It tracks whether a conversion run is in progress, latches a "result ready" interrupt flag, keeps an interrupt enable bit and drives a registered interrupt request line. A run is begun by any of several start sources: a software start, an external trigger or a timer. It ends on its own after one conversion in single-shot mode. In continuous or pause mode it ends only when software forces a stop.

The CPU sees a three-bit register slice. Bit 2 is the run flag, bit 1 the interrupt flag and bit 0 the interrupt enable. The run flag and the interrupt flag can only be cleared by writing 0; writing 1 to either leaves it unchanged. During a read-modify-write access both read back as 1, so that a write-back of the read value does not clear them by accident. A DMA-style service acknowledge also clears the interrupt flag. A stop write produces a one-cycle stop command toward the converter.

Top module: `adc_ctl_status`

## Requirements
- R1: A write with bit 2 of `wr_data` at 0 makes `busy` 0 after the next clock edge, and `stop_cmd` is 1 for exactly that one following cycle.
- R2: A write with bit 2 at 1 leaves `busy` unchanged.
- R3: Any bit of `start_req` (bit 0 software, bit 1 external trigger, bit 2 timer) sets `busy` at the next edge, unless a stop write is in the same cycle.
- R4: In single-shot mode (`mode` = 0), `conv_done` with no start and no stop clears `busy` at the next edge.
- R5: In any mode other than 0 (1 continuous, 2 pause, 3 treated as continuous), `conv_done` leaves `busy` set.
- R6: `conv_done` together with `result_stored` sets the interrupt flag. `conv_done` without `result_stored` does not set it.
- R7: A write with bit 1 at 0 clears the interrupt flag, and bit 1 at 1 leaves it unchanged. If a set event arrives in the same cycle as a clear, the flag ends up 1.
- R8: `svc_ack` clears the interrupt flag at the next edge unless a set event arrives in the same cycle.
- R9: Every write loads bit 0 into the interrupt enable. `irq` is a register equal to the flag AND the enable as they stand after each edge.
- R10: `rd_data` is {busy, flag, enable} in bits 2..0. While `rmw` is 1, bits 2 and 1 read as 1.
- R11: A stop write in the same cycle as any start request leaves `busy` at 0.
- R12: During reset, `busy`, the interrupt flag, the enable, `irq` and `stop_cmd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 3 | Write data: bit 2 run, bit 1 flag, bit 0 enable |
| rmw | input | 1 | Current access is a read-modify-write |
| rd_data | output | 3 | Read data: bit 2 run, bit 1 flag, bit 0 enable |
| start_req | input | 3 | Start pulses: bit 0 software, bit 1 external, bit 2 timer |
| conv_done | input | 1 | Conversion finished strobe |
| result_stored | input | 1 | Result written to the data register with this strobe |
| mode | input | 2 | 0 single-shot, 1 continuous, 2 pause |
| svc_ack | input | 1 | DMA-style service started for the interrupt |
| busy | output | 1 | Conversion run in progress |
| irq | output | 1 | Interrupt request |
| stop_cmd | output | 1 | One-cycle forced stop command to the converter |

## Verification
The bench targets a stop write that coincides with a timer start. If the design gave the start priority, it would leave `busy` high. It also drives `conv_done` in continuous and pause mode: a design that cleared `busy` there would end a run on its own. Set and clear of the interrupt flag in the same cycle is covered too, because a design with the wrong priority would lose a completion. Read-modify-write reads are checked so that a design that returned live values would let a write-back clear the flags. A long pseudo-random phase then compares every output against a behavioural model on every cycle.

// File: rtl/adcctl_pkg.sv
package adcctl_pkg;

    localparam int unsigned CSR_W     = 3;
    localparam int unsigned NUM_START = 3;

    localparam int unsigned BIT_EN   = 0;
    localparam int unsigned BIT_FLAG = 1;
    localparam int unsigned BIT_RUN  = 2;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_CONT   = 2'd1,
        MODE_PAUSE  = 2'd2,
        MODE_RSVD   = 2'd3
    } conv_mode_e;

    typedef struct packed {
        logic stop_req;
        logic flag_clr;
        logic en_wr;
        logic en_val;
    } wr_cmd_t;

    typedef struct packed {
        logic start;
        logic done;
        logic set_flag;
        logic svc;
    } evt_t;

    function automatic logic ends_on_done(conv_mode_e m);
        return m == MODE_SINGLE;
    endfunction

endpackage

// File: rtl/adc_reg_if.sv
module adc_reg_if
    import adcctl_pkg::*;
#(
    parameter int unsigned W = CSR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rmw,
    input  logic         run_q,
    input  logic         flag_q,
    input  logic         en_q,
    output wr_cmd_t      cmd,
    output logic [W-1:0] rd_data
);

    always_comb begin
        cmd.stop_req = wr_en && !wr_data[BIT_RUN];
        cmd.flag_clr = wr_en && !wr_data[BIT_FLAG];
        cmd.en_wr    = wr_en;
        cmd.en_val   = wr_data[BIT_EN];
    end

    always_comb begin
        rd_data           = '0;
        rd_data[BIT_RUN]  = run_q  | rmw;
        rd_data[BIT_FLAG] = flag_q | rmw;
        rd_data[BIT_EN]   = en_q;
    end

    // R10: read-modify-write hides the write-0-clear flags
    a_r10_rmw_reads_one: assert property (@(posedge clk) disable iff (rst)
        rmw |-> (rd_data[BIT_RUN] && rd_data[BIT_FLAG]));

endmodule

// File: rtl/adc_run_tracker.sv
module adc_run_tracker
    import adcctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stop_req,
    input  evt_t       evt,
    input  conv_mode_e mode,
    output logic       busy_o,
    output logic       stop_cmd_o
);

    logic busy_q, busy_d;
    logic stop_q;

    always_comb begin
        busy_d = busy_q;
        if (stop_req)
            busy_d = 1'b0;
        else if (evt.start)
            busy_d = 1'b1;
        else if (evt.done && ends_on_done(mode))
            busy_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            stop_q <= 1'b0;
        end else begin
            busy_q <= busy_d;
            stop_q <= stop_req;
        end
    end

    assign busy_o     = busy_q;
    assign stop_cmd_o = stop_q;

    a_r1_stop_clears_run: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> (!busy_o && stop_cmd_o));

    a_r11_stop_beats_start: assert property (@(posedge clk) disable iff (rst)
        (stop_req && evt.start) |=> !busy_o);

    a_r3_start_sets_run: assert property (@(posedge clk) disable iff (rst)
        (evt.start && !stop_req) |=> busy_o);

    a_r4_single_self_ends: assert property (@(posedge clk) disable iff (rst)
        (evt.done && mode == MODE_SINGLE && !evt.start && !stop_req) |=> !busy_o);

    a_r5_free_run_holds: assert property (@(posedge clk) disable iff (rst)
        (busy_o && mode != MODE_SINGLE && !stop_req) |=> busy_o);

endmodule

// File: rtl/adc_irq_unit.sv
module adc_irq_unit
    import adcctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_cmd_t cmd,
    input  evt_t    evt,
    output logic    flag_o,
    output logic    en_o,
    output logic    irq_o
);

    logic flag_q, flag_d;
    logic en_q, en_d;
    logic irq_q;

    always_comb begin
        flag_d = flag_q;
        if (evt.set_flag)
            flag_d = 1'b1;
        else if (cmd.flag_clr || evt.svc)
            flag_d = 1'b0;
        en_d = cmd.en_wr ? cmd.en_val : en_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            en_q   <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            flag_q <= flag_d;
            en_q   <= en_d;
            irq_q  <= flag_d & en_d;
        end
    end

    assign flag_o = flag_q;
    assign en_o   = en_q;
    assign irq_o  = irq_q;

    a_r6_done_sets_flag: assert property (@(posedge clk) disable iff (rst)
        evt.set_flag |=> flag_o);

    a_r8_service_clears: assert property (@(posedge clk) disable iff (rst)
        (evt.svc && !evt.set_flag) |=> !flag_o);

    a_r9_irq_needs_both: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (flag_o && en_o));

    a_r9_irq_when_both: assert property (@(posedge clk) disable iff (rst)
        (flag_o && en_o) |-> irq_o);

endmodule

// File: rtl/adc_ctl_status.sv
module adc_ctl_status
    import adcctl_pkg::*;
#(
    parameter int unsigned W  = CSR_W,
    parameter int unsigned NS = NUM_START
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rmw,
    output logic [W-1:0]  rd_data,
    input  logic [NS-1:0] start_req,
    input  logic          conv_done,
    input  logic          result_stored,
    input  logic [1:0]    mode,
    input  logic          svc_ack,
    output logic          busy,
    output logic          irq,
    output logic          stop_cmd
);

    wr_cmd_t    cmd;
    evt_t       evt;
    conv_mode_e mode_e;
    logic       flag_q, en_q;

    assign mode_e = conv_mode_e'(mode);

    always_comb begin
        evt.start    = |start_req;
        evt.done     = conv_done;
        evt.set_flag = conv_done && result_stored;
        evt.svc      = svc_ack;
    end

    adc_reg_if #(.W(W)) u_reg_if (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rmw     (rmw),
        .run_q   (busy),
        .flag_q  (flag_q),
        .en_q    (en_q),
        .cmd     (cmd),
        .rd_data (rd_data)
    );

    adc_run_tracker u_run (
        .clk        (clk),
        .rst        (rst),
        .stop_req   (cmd.stop_req),
        .evt        (evt),
        .mode       (mode_e),
        .busy_o     (busy),
        .stop_cmd_o (stop_cmd)
    );

    adc_irq_unit u_irq (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .evt    (evt),
        .flag_o (flag_q),
        .en_o   (en_q),
        .irq_o  (irq)
    );

    // R12: outputs quiet in the cycle after a reset edge
    a_r12_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !irq && !stop_cmd));

endmodule

// File: tb/tb_adc_ctl_status.sv
`timescale 1ns/1ps
module tb_adc_ctl_status;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_data = '0;
    logic       rmw = 1'b0;
    logic [2:0] rd_data;
    logic [2:0] start_req = '0;
    logic       conv_done = 1'b0;
    logic       result_stored = 1'b0;
    logic [1:0] mode = '0;
    logic       svc_ack = 1'b0;
    logic       busy, irq, stop_cmd;

    always #4 clk = ~clk;

    adc_ctl_status dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rmw(rmw),
        .rd_data(rd_data), .start_req(start_req), .conv_done(conv_done),
        .result_stored(result_stored), .mode(mode), .svc_ack(svc_ack),
        .busy(busy), .irq(irq), .stop_cmd(stop_cmd)
    );

    int checks = 0;
    int fails  = 0;
    bit m_busy = 0, m_flag = 0, m_en = 0, m_irq = 0, m_stop = 0;
    logic [31:0] lfsr = 32'h1ACE_5EED;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic [2:0] d, input logic rm,
                       input logic [2:0] st, input logic dn, input logic sr,
                       input logic [1:0] md, input logic sv);
        bit stop, start, setf, clrf;
        wr_en = w; wr_data = d; rmw = rm; start_req = st;
        conv_done = dn; result_stored = sr; mode = md; svc_ack = sv;
        stop  = w && !d[2];
        start = st != 3'b000;
        setf  = dn && sr;
        clrf  = (w && !d[1]) || sv;
        if (rst) begin
            m_busy = 0; m_flag = 0; m_en = 0; m_irq = 0; m_stop = 0;
        end else begin
            if (stop) m_busy = 0;
            else if (start) m_busy = 1;
            else if (dn && md == 2'd0) m_busy = 0;
            if (setf) m_flag = 1;
            else if (clrf) m_flag = 0;
            if (w) m_en = d[0];
            m_irq  = m_flag && m_en;
            m_stop = stop;
        end
        @(posedge clk);
        @(negedge clk);
        chk("R2/R3/R4/R5 busy model", {7'd0, busy}, {7'd0, m_busy});
        chk("R9 irq model", {7'd0, irq}, {7'd0, m_irq});
        chk("R1 stop_cmd model", {7'd0, stop_cmd}, {7'd0, m_stop});
        chk("R10 rd_data model", {5'd0, rd_data},
            {5'd0, m_busy | rm, m_flag | rm, m_en});
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst = 1'b1;
        cyc(1, 3'b111, 0, 3'b111, 1, 1, 0, 0);
        cyc(0, 3'b000, 0, 3'b000, 0, 0, 0, 0);
        chk("R12 reset busy", {7'd0, busy}, 8'd0);
        chk("R12 reset irq", {7'd0, irq}, 8'd0);
        chk("R12 reset stop_cmd", {7'd0, stop_cmd}, 8'd0);
        chk("R12 reset rd_data", {5'd0, rd_data}, 8'd0);
        rst = 1'b0;

        cyc(0, 3'b000, 0, 3'b001, 0, 0, 0, 0);
        chk("R3 software start", {7'd0, busy}, 8'd1);
        cyc(0, 3'b000, 0, 3'b000, 1, 1, 0, 0);
        chk("R4 single-shot ends", {7'd0, busy}, 8'd0);
        chk("R6 flag set", {7'd0, rd_data[1]}, 8'd1);
        cyc(1, 3'b111, 0, 3'b000, 0, 0, 0, 0);
        chk("R2 write 1 no start", {7'd0, busy}, 8'd0);
        chk("R7 write 1 keeps flag", {7'd0, rd_data[1]}, 8'd1);
        chk("R9 irq raised", {7'd0, irq}, 8'd1);
        cyc(0, 3'b000, 1, 3'b000, 0, 0, 0, 0);
        chk("R10 rmw read", {5'd0, rd_data}, 8'd7);
        cyc(0, 3'b000, 0, 3'b000, 0, 0, 0, 1);
        chk("R8 service clears", {7'd0, rd_data[1]}, 8'd0);
        chk("R9 irq drops", {7'd0, irq}, 8'd0);
        cyc(0, 3'b000, 0, 3'b010, 0, 0, 1, 0);
        chk("R3 external start", {7'd0, busy}, 8'd1);
        cyc(0, 3'b000, 0, 3'b000, 1, 1, 1, 0);
        chk("R5 continuous holds", {7'd0, busy}, 8'd1);
        cyc(0, 3'b000, 0, 3'b000, 1, 1, 2, 0);
        chk("R5 pause holds", {7'd0, busy}, 8'd1);
        cyc(1, 3'b011, 0, 3'b000, 0, 0, 2, 0);
        chk("R1 forced stop", {7'd0, busy}, 8'd0);
        chk("R1 stop_cmd pulse", {7'd0, stop_cmd}, 8'd1);
        chk("R7 flag kept by write 1", {7'd0, rd_data[1]}, 8'd1);
        cyc(0, 3'b000, 0, 3'b000, 0, 0, 2, 0);
        chk("R1 stop_cmd one cycle", {7'd0, stop_cmd}, 8'd0);
        cyc(1, 3'b001, 0, 3'b100, 0, 0, 1, 0);
        chk("R11 stop beats timer start", {7'd0, busy}, 8'd0);
        chk("R7 write 0 clears flag", {7'd0, rd_data[1]}, 8'd0);
        cyc(1, 3'b101, 0, 3'b000, 1, 1, 1, 0);
        chk("R7 set wins over clear", {7'd0, rd_data[1]}, 8'd1);
        cyc(1, 3'b101, 0, 3'b000, 0, 0, 1, 0);
        cyc(0, 3'b000, 0, 3'b000, 1, 0, 1, 0);
        chk("R6 done without store", {7'd0, rd_data[1]}, 8'd0);
        cyc(1, 3'b110, 0, 3'b000, 1, 1, 0, 0);
        chk("R9 enable off masks irq", {7'd0, irq}, 8'd0);

        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            cyc(lfsr[2:0] == 3'd0, lfsr[5:3], lfsr[7:6] == 2'd0,
                (lfsr[9:8] == 2'd0) ? lfsr[12:10] : 3'b000,
                lfsr[14:13] == 2'd0, lfsr[15], lfsr[17:16],
                lfsr[20:18] == 3'd0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule